// File: doc/BRIEF.md
# Debug Register Access Controller

This block holds the debug register set of a processor core: four breakpoint address registers, one debug status register and one debug control register. A single move-style port reaches them. Each cycle the port carries a strobe, a read/write direction, a 3-bit register index and write data. The block checks the current privilege level and a debug-extensions enable input. It then either completes the access or raises a fault pulse: general protection or undefined opcode.

Index 0 to 3 selects an address register. Index 6 selects the status register and index 7 the control register. Indices 4 and 5 are alternate names for 6 and 7 while the extensions enable is low. While it is high, indices 4 and 5 raise an undefined-opcode fault. Reads return data in the same cycle. Writes land on the next clock edge.

The status register models fixed reserved bits, a bit that always reads as zero, and two optional feature bits chosen by parameters. The status and control contents are exported continuously to a separate breakpoint detection unit. That unit can load the writable status bits back into the register.

Top module: `dbgreg_ctrl`

## Requirements
- R1: With privilege 0, index 0..3 writes the full data word into address register 0..3. A later read of the same index returns that word.
- R2: When acc_valid is high and cpl is not 0, fault_gp is high in that cycle. acc_rdata is 0 and no register changes.
- R3: With dbg_ext_en low, index 4 reads and writes the status register exactly as index 6 does. Index 5 reads and writes the control register exactly as index 7 does.
- R4: With dbg_ext_en high and privilege 0, an access to index 4 or 5 raises fault_ud for that cycle. acc_rdata is 0 and no register changes. Indices 6 and 7 still work.
- R5: fault_gp and fault_ud are never high together. When privilege is nonzero and an index 4/5 access has dbg_ext_en high, only fault_gp is raised.
- R6: The status register is written only through mask 0x0000E00F (bits 3:0 and 15:13). It reads as (stored & 0xE00F) | 0xFFFF0FF0 in the default configuration. Bits 10:4 and 31:16 read 1, bit 12 reads 0, and bit 11 reads 1 when its feature is absent. Writes to all of these bits have no effect.
- R7: After reset, all address registers and the control register read 0, and the status register reads 0xFFFF0FF0.
- R8: Read data and fault flags are combinational with the strobe. With acc_valid low, no fault is raised and acc_rdata is 0. A write is visible from the next cycle on.
- R9: When det_upd_valid is high, the writable status bits take det_upd_data from the next cycle on. This overrides a port write to the status register in the same cycle.
- R10: dstat_o and dctl_o always show the current read value of the status and control registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 3 | Debug register index 0..7 |
| acc_wdata | input | XLEN | Write data |
| cpl | input | 2 | Current privilege level |
| dbg_ext_en | input | 1 | Debug-extensions enable (1 = indices 4/5 fault) |
| det_upd_valid | input | 1 | Status load request from detection unit |
| det_upd_data | input | XLEN | Status value from detection unit (writable bits used) |
| acc_rdata | output | XLEN | Read data, 0 on fault or idle |
| fault_gp | output | 1 | General-protection fault pulse |
| fault_ud | output | 1 | Undefined-opcode fault pulse |
| dstat_o | output | XLEN | Status register read view |
| dctl_o | output | XLEN | Control register read view |

## Verification
A wrong stored bit in any register appears at the ports on the first read of its index. For status and control it appears at once on dstat_o or dctl_o, which the bench compares every cycle against its model. A faulting access that wrongly updates state shows on the exported views one cycle later, or on the next read of an address register. A decode error in the alias or privilege gating shows in the same cycle as a wrong fault pulse or wrong read data.

// File: rtl/dbgreg_pkg.sv
package dbgreg_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CTL  = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    // Status bits that software and the detection unit may change.
    function automatic logic [63:0] stat_wr_mask(input bit has_lock, input bit has_txn);
        logic [63:0] m;
        m = 64'h0000_0000_0000_E00F;
        if (has_lock) m[11] = 1'b1;
        if (has_txn)  m[16] = 1'b1;
        return m;
    endfunction

    // Status bits that are read-only and read back as one.
    function automatic logic [63:0] stat_ro_ones(input bit has_lock, input bit has_txn);
        logic [63:0] m;
        m = 64'h0000_0000_FFFE_07F0;
        if (!has_lock) m[11] = 1'b1;
        if (!has_txn)  m[16] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/dbgreg_gate.sv
module dbgreg_gate
    import dbgreg_pkg::*;
(
    input  logic       acc_valid,
    input  logic       acc_write,
    input  logic [2:0] acc_idx,
    input  logic [1:0] cpl,
    input  logic       dbg_ext_en,
    output logic       fault_gp,
    output logic       fault_ud,
    output logic       wr_en,
    output sel_e       sel,
    output logic [1:0] slot
);
    logic is_alias;
    logic ok;

    always_comb begin
        is_alias = (acc_idx[2:1] == 2'b10);
        // privilege fault wins over the alias fault
        fault_gp = acc_valid && (cpl != 2'd0);
        fault_ud = acc_valid && !fault_gp && dbg_ext_en && is_alias;
        ok       = acc_valid && !fault_gp && !fault_ud;
        wr_en    = ok && acc_write;
        slot     = acc_idx[1:0];
        if (!ok)
            sel = SEL_NONE;
        else if (!acc_idx[2])
            sel = SEL_ADDR;
        else if (!acc_idx[0])
            sel = SEL_STAT;
        else
            sel = SEL_CTL;
    end

endmodule

// File: rtl/dbgreg_file.sv
module dbgreg_file
    import dbgreg_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter bit HAS_LOCK = 1'b0,
    parameter bit HAS_TXN  = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  sel_e            sel,
    input  logic [1:0]      slot,
    input  logic [XLEN-1:0] wdata,
    input  logic            det_v,
    input  logic [XLEN-1:0] det_d,
    output logic [XLEN-1:0] rd_data,
    output logic [XLEN-1:0] stat_view,
    output logic [XLEN-1:0] ctl_view
);
    localparam int NADDR = 4;
    localparam logic [63:0] WM64   = stat_wr_mask(HAS_LOCK, HAS_TXN);
    localparam logic [63:0] RO64   = stat_ro_ones(HAS_LOCK, HAS_TXN);
    localparam logic [63:0] LOW64  = 64'h0000_0000_FFFF_FFFF;
    localparam logic [63:0] RST64  = WM64 & 64'h0000_0000_0001_0800;
    localparam logic [XLEN-1:0] WM   = WM64[XLEN-1:0];
    localparam logic [XLEN-1:0] RO   = RO64[XLEN-1:0];
    localparam logic [XLEN-1:0] LOWM = LOW64[XLEN-1:0];
    localparam logic [XLEN-1:0] RSTS = RST64[XLEN-1:0];

    typedef struct packed {
        logic [NADDR-1:0][XLEN-1:0] addr;
        logic [XLEN-1:0]            stat;
        logic [XLEN-1:0]            ctl;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (sel)
                SEL_ADDR: r_d.addr[slot] = wdata;
                SEL_STAT: r_d.stat       = wdata & WM;
                SEL_CTL:  r_d.ctl        = wdata & LOWM;
                default:  ;
            endcase
        end
        // detection unit has priority over the port
        if (det_v)
            r_d.stat = det_d & WM;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.addr <= '0;
            r_q.stat <= RSTS;
            r_q.ctl  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        stat_view = (r_q.stat & WM) | RO;
        ctl_view  = r_q.ctl & LOWM;
        case (sel)
            SEL_ADDR: rd_data = r_q.addr[slot];
            SEL_STAT: rd_data = stat_view;
            SEL_CTL:  rd_data = ctl_view;
            default:  rd_data = '0;
        endcase
    end

    // R8
    ctl_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CTL && !det_v) |=> (ctl_view == ($past(wdata) & LOWM)));

    // R9
    det_update_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_v |=> ((stat_view & WM) == ($past(det_d) & WM)));

    // R6
    stat_ro_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_view & RO) == RO));

endmodule

// File: rtl/dbgreg_ctrl.sv
module dbgreg_ctrl
    import dbgreg_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter bit HAS_LOCK = 1'b0,
    parameter bit HAS_TXN  = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic            acc_write,
    input  logic [2:0]      acc_idx,
    input  logic [XLEN-1:0] acc_wdata,
    input  logic [1:0]      cpl,
    input  logic            dbg_ext_en,
    input  logic            det_upd_valid,
    input  logic [XLEN-1:0] det_upd_data,
    output logic [XLEN-1:0] acc_rdata,
    output logic            fault_gp,
    output logic            fault_ud,
    output logic [XLEN-1:0] dstat_o,
    output logic [XLEN-1:0] dctl_o
);
    logic       wr_en;
    sel_e       sel;
    logic [1:0] slot;

    dbgreg_gate u_gate (
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_idx    (acc_idx),
        .cpl        (cpl),
        .dbg_ext_en (dbg_ext_en),
        .fault_gp   (fault_gp),
        .fault_ud   (fault_ud),
        .wr_en      (wr_en),
        .sel        (sel),
        .slot       (slot)
    );

    dbgreg_file #(
        .XLEN     (XLEN),
        .HAS_LOCK (HAS_LOCK),
        .HAS_TXN  (HAS_TXN)
    ) u_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .sel       (sel),
        .slot      (slot),
        .wdata     (acc_wdata),
        .det_v     (det_upd_valid),
        .det_d     (det_upd_data),
        .rd_data   (acc_rdata),
        .stat_view (dstat_o),
        .ctl_view  (dctl_o)
    );

    // R5
    gp_over_ud_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_gp && fault_ud));

    // R2
    fault_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_gp || fault_ud) |-> !wr_en);

    // R4
    fault_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_gp || fault_ud) |-> (acc_rdata == '0));

    // R6
    stat_bit12_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dstat_o[12]);

    // R8
    idle_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!fault_gp && !fault_ud && acc_rdata == '0));

endmodule

// File: tb/dbgreg_ctrl_tb_top.sv
module dbgreg_ctrl_tb_top;
    localparam int CLK_PER = 10;
    localparam logic [31:0] WMASK = 32'h0000_E00F;
    localparam logic [31:0] RONES = 32'hFFFF_0FF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [2:0]  acc_idx = '0;
    logic [31:0] acc_wdata = '0;
    logic [1:0]  cpl = '0;
    logic        dbg_ext_en = 1'b0;
    logic        det_upd_valid = 1'b0;
    logic [31:0] det_upd_data = '0;
    logic [31:0] acc_rdata;
    logic        fault_gp;
    logic        fault_ud;
    logic [31:0] dstat_o;
    logic [31:0] dctl_o;

    int n_checks = 0;
    int n_fail = 0;

    logic [31:0] m_addr [4];
    logic [31:0] m_stat;
    logic [31:0] m_ctl;

    always #(CLK_PER/2) clk = ~clk;

    dbgreg_ctrl dut_i (
        .clk (clk), .rst_n (rst_n), .acc_valid (acc_valid), .acc_write (acc_write),
        .acc_idx (acc_idx), .acc_wdata (acc_wdata), .cpl (cpl), .dbg_ext_en (dbg_ext_en),
        .det_upd_valid (det_upd_valid), .det_upd_data (det_upd_data),
        .acc_rdata (acc_rdata), .fault_gp (fault_gp), .fault_ud (fault_ud),
        .dstat_o (dstat_o), .dctl_o (dctl_o)
    );

    function automatic logic [31:0] stat_rd();
        return (m_stat & WMASK) | RONES;
    endfunction

    task automatic check(input bit good, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock of stimulus, compared against the behavioural model.
    task automatic cyc(input bit v, input bit w, input logic [2:0] idx, input logic [31:0] wd,
                       input logic [1:0] pl, input bit ext, input bit dv, input logic [31:0] dd,
                       input string tag);
        bit gp, ud, ok;
        logic [31:0] exp_rd;
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_idx = idx; acc_wdata = wd;
        cpl = pl; dbg_ext_en = ext; det_upd_valid = dv; det_upd_data = dd;
        #(CLK_PER/4);
        gp = v && (pl != 0);
        ud = v && !gp && ext && (idx == 3'd4 || idx == 3'd5);
        ok = v && !gp && !ud;
        exp_rd = 32'h0;
        if (ok) begin
            if (idx < 3'd4) exp_rd = m_addr[idx[1:0]];
            else if (idx[0] == 1'b0) exp_rd = stat_rd();
            else exp_rd = m_ctl;
        end
        check(acc_rdata == exp_rd, {tag, " rdata"}, acc_rdata, exp_rd);
        check(fault_gp == gp, "R2 fault_gp", {31'd0, fault_gp}, {31'd0, gp});
        check(fault_ud == ud, "R4 fault_ud", {31'd0, fault_ud}, {31'd0, ud});
        check(dstat_o == stat_rd(), "R10 dstat_o", dstat_o, stat_rd());
        check(dctl_o == m_ctl, "R10 dctl_o", dctl_o, m_ctl);
        if (ok && w) begin
            if (idx < 3'd4) m_addr[idx[1:0]] = wd;
            else if (idx[0] == 1'b0) m_stat = wd & WMASK;
            else m_ctl = wd;
        end
        if (dv) m_stat = dd & WMASK;
    endtask

    initial begin
        #(CLK_PER * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_addr[i] = '0;
        m_stat = '0;
        m_ctl = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #(CLK_PER/4);
        // R7 reset state
        check(dstat_o == 32'hFFFF_0FF0, "R7 status reset", dstat_o, 32'hFFFF_0FF0);
        check(dctl_o == 32'h0, "R7 control reset", dctl_o, 32'h0);
        for (int i = 0; i < 4; i++) cyc(1, 0, 3'(i), 0, 0, 0, 0, 0, "R7 addr reset");

        // R1 address registers, R8 write visible next cycle
        for (int i = 0; i < 4; i++) cyc(1, 1, 3'(i), 32'hA5A5_0000 + 32'(i * 17), 0, 0, 0, 0, "R1 write");
        for (int i = 0; i < 4; i++) cyc(1, 0, 3'(i), 0, 0, 0, 0, 0, "R1 readback");
        cyc(1, 1, 3'd2, 32'hFFFF_FFFF, 0, 0, 0, 0, "R8 write");
        cyc(1, 0, 3'd2, 0, 0, 0, 0, 0, "R8 next cycle");

        // R3 aliases with extensions off
        cyc(1, 1, 3'd7, 32'h0000_0155, 0, 0, 0, 0, "R3 ctl via 7");
        cyc(1, 0, 3'd5, 0, 0, 0, 0, 0, "R3 ctl via 5");
        cyc(1, 1, 3'd5, 32'h1234_5678, 0, 0, 0, 0, "R3 ctl write 5");
        cyc(1, 0, 3'd7, 0, 0, 0, 0, 0, "R3 ctl read 7");
        cyc(1, 1, 3'd4, 32'hFFFF_FFFF, 0, 0, 0, 0, "R3 stat write 4");
        cyc(1, 0, 3'd6, 0, 0, 0, 0, 0, "R6 stat all ones");
        check(dstat_o == 32'hFFFF_EFFF, "R6 bit12 zero", dstat_o, 32'hFFFF_EFFF);
        cyc(1, 1, 3'd6, 32'h0000_0000, 0, 0, 0, 0, "R6 stat clear");
        cyc(1, 0, 3'd4, 0, 0, 0, 0, 0, "R6 reserved ones");
        check(dstat_o == 32'hFFFF_0FF0, "R6 stat cleared", dstat_o, 32'hFFFF_0FF0);

        // R2 privilege fault leaves state
        cyc(1, 1, 3'd0, 32'hDEAD_BEEF, 2'd3, 0, 0, 0, "R2 write cpl3");
        cyc(1, 1, 3'd7, 32'hDEAD_BEEF, 2'd1, 0, 0, 0, "R2 ctl cpl1");
        cyc(1, 0, 3'd0, 0, 0, 0, 0, 0, "R2 addr kept");
        cyc(1, 0, 3'd7, 0, 0, 0, 0, 0, "R2 ctl kept");

        // R4 undefined-opcode on 4/5
        cyc(1, 1, 3'd4, 32'h0000_000F, 0, 1, 0, 0, "R4 stat via 4");
        cyc(1, 1, 3'd5, 32'h0000_00AA, 0, 1, 0, 0, "R4 ctl via 5");
        cyc(1, 0, 3'd6, 0, 0, 1, 0, 0, "R4 idx6 ok");
        cyc(1, 0, 3'd7, 0, 0, 1, 0, 0, "R4 idx7 ok");

        // R5 precedence
        cyc(1, 1, 3'd5, 32'h0, 2'd2, 1, 0, 0, "R5 gp only");
        cyc(1, 0, 3'd4, 0, 2'd1, 1, 0, 0, "R5 gp only read");

        // R8 idle: no fault even at nonzero privilege
        cyc(0, 1, 3'd4, 32'hFFFF_FFFF, 2'd3, 1, 0, 0, "R8 idle");

        // R9 detection update and priority
        cyc(0, 0, 3'd0, 0, 0, 0, 1, 32'h0000_4003, "R9 det load");
        cyc(1, 1, 3'd6, 32'h0000_000C, 0, 0, 1, 32'h0000_8001, "R9 det vs write");
        cyc(1, 0, 3'd6, 0, 0, 0, 0, 0, "R9 det won");
        check(dstat_o == 32'hFFFF_8FF1, "R9 status value", dstat_o, 32'hFFFF_8FF1);

        // mixed patterns
        for (int k = 0; k < 600; k++) begin
            cyc(1'($urandom), 1'($urandom), 3'($urandom), $urandom,
                ($urandom % 4 == 0) ? 2'($urandom) : 2'd0, 1'($urandom),
                ($urandom % 8 == 0), $urandom, "R1 mixed");
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule